// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host write port of a NOR-style flash controller. It turns a stream of single-cycle bus writes, each an address and a data word, into multi-cycle flash commands. It keeps track of where the current sequence stands, holds the mode the memory is in, and latches the target addresses and data of a program operation. When a program command completes, the block gives a one-cycle start strobe to a separate program engine. It then waits for that engine to report completion, and whether the operation failed.

The recognised commands are listed below.
- Two unlock writes, followed by a third write that carries the command code.
- A one-cycle reset and a three-cycle reset.
- Standard program.
- Auto-select, with bank selection.
- The one-write query.
- Two fast program forms that take several address/data writes after one setup write.
- An unlock-bypass sub-mode with shortened program and exit sequences.

Unlock and command addresses are matched on the low address bits. In byte mode these bits are shifted by one, so the key sits at bits 12:1 instead of 11:0. The bank is taken from the top address bits of the write that selects auto-select.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode_o is read (0) and prog_start_o is low. The mode encoding is read=0, auto-select=1, query=2, bypass=3, busy=4, error=5.
- R2: A write that does not continue a valid sequence returns the mode to read and restarts sequence tracking. From error mode it stays in error instead. An example is an unlock write AA at key 555h followed by a write that is not 55 at key 2AAh.
- R3: Standard program is four writes: AA@555h, 55@2AAh, A0@555h, then the target address and data. One cycle after the fourth write, the outputs are as follows.
  - prog_start_o pulses for one cycle.
  - prog_len_o is 1.
  - Slot 0 holds the address and data of the fourth write.
  - mode_o is busy.
- R4: Data F0 written from the idle sequence at any address resets the mode. The three-write AA@555h, 55@2AAh, F0 also resets it. Either reset clears error mode to read.
- R5: AA@555h, 55@2AAh, 90@555h enters auto-select from read or auto-select. The bank output is taken from the top address bits of the third write. With no further writes the mode stays auto-select.
- R6: Data 98 at key 055h enters query from read or auto-select. A reset in query returns to the mode that was active before the query. From query entered out of auto-select, two resets are needed to reach read.
- R7: Four-byte fast program takes five writes: setup 56@555h, then four address/data writes. The fourth data write starts the engine with prog_len_o=4, and slots 0 to 3 hold the four writes in order.
- R8: Two-word fast program takes three writes: setup 50@555h, then two address/data writes. It starts the engine with prog_len_o=2.
- R9: Each fast-program address after the first must match the first address on all bits except bits 1:0 for the four-byte form, or bit 0 for the two-word form. On a mismatch the mode returns to read and no start is issued.
- R10: AA@555h, 55@2AAh, 20@555h enters bypass from read. In bypass the following rules apply.
  - A0 then an address/data write starts a program with prog_len_o=1.
  - 90 then 00 exits to read.
  - An F0 write leaves the mode in bypass.
- R11: While busy, every write is ignored. eng_done_i ends busy.
  - With eng_fail_i high, the mode goes to error.
  - Otherwise it returns to bypass if the program began there, and to read if not.
- R12: With byte_mode_i high, the key is taken from address bits 12:1, so the unlock addresses are AAAh and 554h/555h. With byte_mode_i low, the key is taken from bits 11:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | ADDR_W | Write address (top bits select bank) |
| data_i | input | DATA_W | Write data; command codes use bits 7:0 |
| byte_mode_i | input | 1 | 1 = byte addressing for command keys |
| eng_done_i | input | 1 | Program engine completion pulse |
| eng_fail_i | input | 1 | Qualifies eng_done_i as a failed operation |
| mode_o | output | 3 | Current mode (encoding in R1) |
| asel_bank_o | output | BANK_W | Bank chosen by the last auto-select command |
| prog_start_o | output | 1 | One-cycle program start strobe |
| prog_len_o | output | 3 | Number of valid slots: 1, 2 or 4 |
| prog_addr_o | output | 4*ADDR_W | Latched addresses, slot k at bits k*ADDR_W |
| prog_data_o | output | 4*DATA_W | Latched data, slot k at bits k*DATA_W |

## Verification
The bench goes after several corner cases, each of which a faulty design would get visibly wrong:
- **Query return path.** A design that always returned to read would leave auto-select one reset early.
- **F0 in bypass.** A design that treated F0 as a plain reset would drop out of bypass.
- **Fast-program address grouping.** A decoder that skipped the check, or masked the wrong bits, would start the engine on a scattered address set.
- **Writes during busy.** A decoder that did not block them would decode a reset mid-operation and leave busy early.
- **Error and bypass after completion.** A design that lost the bypass return flag, or ignored the failure flag, would land in the wrong mode once the engine finished.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    M_READ = 3'd0, M_ASEL = 3'd1, M_QRY = 3'd2,
    M_BYP  = 3'd3, M_BUSY = 3'd4, M_ERR = 3'd5
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PGM, S_FAST, S_BPG, S_BEX
  } seq_e;

  localparam logic [7:0] CD_RST   = 8'hF0;
  localparam logic [7:0] CD_PGM   = 8'hA0;
  localparam logic [7:0] CD_ASEL  = 8'h90;
  localparam logic [7:0] CD_BYP   = 8'h20;
  localparam logic [7:0] CD_FAST4 = 8'h56;
  localparam logic [7:0] CD_FAST2 = 8'h50;
  localparam logic [7:0] CD_BEXIT = 8'h00;
endpackage

// File: rtl/fcd_cmd_match.sv
module fcd_cmd_match (
  input  logic [12:0] addr_i,
  input  logic [7:0]  data_i,
  input  logic        byte_mode_i,
  output logic        u1_o,
  output logic        u2_o,
  output logic        qry_o,
  output logic        at_u1_o
);
  logic [11:0] key;

  // byte addressing shifts the command key up by one bit
  assign key     = byte_mode_i ? addr_i[12:1] : addr_i[11:0];
  assign at_u1_o = (key == 12'h555);
  assign u1_o    = at_u1_o && (data_i == 8'hAA);
  assign u2_o    = (key == 12'h2AA) && (data_i == 8'h55);
  assign qry_o   = (key == 12'h055) && (data_i == 8'h98);
endmodule

// File: rtl/fcd_prog_latch.sv
module fcd_prog_latch #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int NSLOT  = 4,
  localparam int IDX_W = $clog2(NSLOT)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         data_i,
  input  logic [2:0]                len_i,
  output logic [NSLOT*ADDR_W-1:0]   addr_o,
  output logic [NSLOT*DATA_W-1:0]   data_o,
  output logic                      grp_ok_o
);
  logic [ADDR_W-1:0] slot_addr [NSLOT];
  logic [ADDR_W-1:0] free_mask;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [DATA_W-1:0] d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_addr[g] <= '0;
        d_q          <= '0;
      end else if (we_i && idx_i == IDX_W'(g)) begin
        slot_addr[g] <= addr_i;
        d_q          <= data_i;
      end
    end
    assign addr_o[g*ADDR_W +: ADDR_W] = slot_addr[g];
    assign data_o[g*DATA_W +: DATA_W] = d_q;
  end

  // four-unit group may vary in bits 1:0, two-unit group only in bit 0
  assign free_mask = (len_i == 3'd4) ? ADDR_W'(3) : ADDR_W'(1);
  assign grp_ok_o  = ((addr_i ^ slot_addr[0]) & ~free_mask) == '0;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int BANK_W = 1,
  localparam int NSLOT = 4,
  localparam int IDX_W = $clog2(NSLOT)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       data_i,
  input  logic                    byte_mode_i,
  input  logic                    eng_done_i,
  input  logic                    eng_fail_i,
  output logic [2:0]              mode_o,
  output logic [BANK_W-1:0]       asel_bank_o,
  output logic                    prog_start_o,
  output logic [2:0]              prog_len_o,
  output logic [NSLOT*ADDR_W-1:0] prog_addr_o,
  output logic [NSLOT*DATA_W-1:0] prog_data_o
);
  mode_e             mode_q, mode_d, qret_q, qret_d, fail_mode, rst_mode;
  seq_e              seq_q, seq_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [2:0]        len_q, len_d;
  logic [IDX_W-1:0]  idx_q, idx_d, lat_idx;
  logic              bret_q, bret_d, start_q, start_d, lat_we;
  logic              u1, u2, qry, at_u1, grp_ok;
  logic [7:0]        cd;

  assign cd = data_i[7:0];

  fcd_cmd_match u_match (
    .addr_i(addr_i[12:0]), .data_i(cd), .byte_mode_i(byte_mode_i),
    .u1_o(u1), .u2_o(u2), .qry_o(qry), .at_u1_o(at_u1)
  );

  assign lat_idx = (seq_q == S_FAST) ? idx_q : '0;

  fcd_prog_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSLOT(NSLOT)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(lat_we), .idx_i(lat_idx),
    .addr_i(addr_i), .data_i(data_i), .len_i(len_q),
    .addr_o(prog_addr_o), .data_o(prog_data_o), .grp_ok_o(grp_ok)
  );

  assign fail_mode = (mode_q == M_ERR) ? M_ERR : M_READ;
  assign rst_mode  = (mode_q == M_QRY) ? qret_q : M_READ;

  always_comb begin
    mode_d = mode_q; seq_d = seq_q; qret_d = qret_q; bank_d = bank_q;
    len_d = len_q; idx_d = idx_q; bret_d = bret_q;
    start_d = 1'b0; lat_we = 1'b0;
    if (mode_q == M_BUSY) begin
      seq_d = S_IDLE;
      if (eng_done_i) mode_d = eng_fail_i ? M_ERR : (bret_q ? M_BYP : M_READ);
    end else if (wr_en_i) begin
      seq_d = S_IDLE;
      case (seq_q)
        S_IDLE: begin
          if (mode_q == M_BYP) begin
            if (cd == CD_PGM)       seq_d = S_BPG;
            else if (cd == CD_ASEL) seq_d = S_BEX;
          end else if (cd == CD_RST) mode_d = rst_mode;
          else if (u1) seq_d = S_U1;
          else if (qry && (mode_q == M_READ || mode_q == M_ASEL)) begin
            qret_d = mode_q; mode_d = M_QRY;
          end else if (mode_q == M_READ && at_u1 && (cd == CD_FAST4 || cd == CD_FAST2)) begin
            seq_d = S_FAST; len_d = (cd == CD_FAST4) ? 3'd4 : 3'd2; idx_d = '0;
          end else mode_d = fail_mode;
        end
        S_U1: begin
          if (u2) seq_d = S_U2;
          else    mode_d = fail_mode;
        end
        S_U2: begin
          if (cd == CD_RST) mode_d = rst_mode;
          else if (cd == CD_PGM && at_u1 && mode_q == M_READ) seq_d = S_PGM;
          else if (cd == CD_ASEL && at_u1 && (mode_q == M_READ || mode_q == M_ASEL)) begin
            mode_d = M_ASEL; bank_d = addr_i[ADDR_W-1 -: BANK_W];
          end else if (cd == CD_BYP && at_u1 && mode_q == M_READ) mode_d = M_BYP;
          else mode_d = fail_mode;
        end
        S_PGM, S_BPG: begin
          lat_we = 1'b1; len_d = 3'd1; start_d = 1'b1; mode_d = M_BUSY;
          bret_d = (seq_q == S_BPG);
        end
        S_FAST: begin
          if (idx_q != '0 && !grp_ok) mode_d = M_READ;
          else begin
            lat_we = 1'b1;
            if ({1'b0, idx_q} == len_q - 3'd1) begin
              start_d = 1'b1; mode_d = M_BUSY; bret_d = 1'b0;
            end else begin
              idx_d = idx_q + 1'b1; seq_d = S_FAST;
            end
          end
        end
        S_BEX: if (cd == CD_BEXIT) mode_d = M_READ;
        default: mode_d = fail_mode;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_READ; seq_q <= S_IDLE; qret_q <= M_READ; bank_q <= '0;
      len_q <= 3'd1; idx_q <= '0; bret_q <= 1'b0; start_q <= 1'b0;
    end else begin
      mode_q <= mode_d; seq_q <= seq_d; qret_q <= qret_d; bank_q <= bank_d;
      len_q <= len_d; idx_q <= idx_d; bret_q <= bret_d; start_q <= start_d;
    end
  end

  assign mode_o       = mode_q;
  assign asel_bank_o  = bank_q;
  assign prog_start_o = start_q;
  assign prog_len_o   = len_q;

  AST_START_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> mode_o == 3'd4); // R3
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |=> !prog_start_o); // R3
  AST_LEN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> $countones(prog_len_o) == 1); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_BUSY && !eng_done_i) |=> mode_q == M_BUSY); // R11
  AST_ERR_ONLY_ON_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != M_ERR && !(eng_done_i && eng_fail_i)) |=> mode_q != M_ERR); // R11
  AST_BYP_KEEPS_F0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_BYP && seq_q == S_IDLE && wr_en_i && cd == CD_RST) |=> mode_q == M_BYP); // R10
  AST_ASEL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_ASEL && !wr_en_i) |=> mode_q == M_ASEL); // R5
endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int AW = 22, DW = 16;
  localparam int RD = 0, AS = 1, QY = 2, BP = 3, BZ = 4, ER = 5;

  logic clk = 0, rst_ni = 0, wr_en = 0, byte_mode = 0, eng_done = 0, eng_fail = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [2:0] mode_o, prog_len_o;
  logic [0:0] asel_bank_o;
  logic prog_start_o;
  logic [4*AW-1:0] prog_addr_o;
  logic [4*DW-1:0] prog_data_o;

  int n_chk = 0, n_fail = 0, exp_mode = RD, exp_qret = RD;

  always #10 clk = ~clk;

  flash_cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr), .data_i(data),
    .byte_mode_i(byte_mode), .eng_done_i(eng_done), .eng_fail_i(eng_fail),
    .mode_o(mode_o), .asel_bank_o(asel_bank_o), .prog_start_o(prog_start_o),
    .prog_len_o(prog_len_o), .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ca(input logic [11:0] key, input logic bank);
    return byte_mode ? {bank, 8'h00, key, 1'b0} : {bank, 9'h000, key};
  endfunction

  function automatic int fail_to(input int m);
    return (m == ER) ? ER : RD;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic engine(input string tag, input bit fail, input int ret);
    chk({tag, " start"}, prog_start_o, 1);
    chk({tag, " busy R3"}, mode_o, BZ);
    wr(ca(12'h555, 0), 16'hF0);   // R11 ignored while busy
    chk("R11 write ignored while busy", mode_o, BZ);
    chk("R3 start single pulse", prog_start_o, 0);
    @(negedge clk); eng_done = 1; eng_fail = fail;
    @(negedge clk); eng_done = 0; eng_fail = 0;
    exp_mode = fail ? ER : ret;
    chk("R11 mode after done", mode_o, exp_mode);
  endtask

  task automatic op_rst1();
    wr(AW'($urandom), 16'h00F0);
    if (exp_mode == QY) exp_mode = exp_qret;
    else if (exp_mode != BP) exp_mode = RD;
    chk("R4/R6/R10 single reset", mode_o, exp_mode);
  endtask

  task automatic op_rst3();
    wr(ca(12'h555, 0), 16'hAA); wr(ca(12'h2AA, 0), 16'h55); wr(ca(12'h555, 1), 16'hF0);
    exp_mode = (exp_mode == QY) ? exp_qret : RD;
    chk("R4/R6 three-cycle reset", mode_o, exp_mode);
  endtask

  task automatic op_asel(input logic b);
    wr(ca(12'h555, 0), 16'hAA); wr(ca(12'h2AA, 0), 16'h55); wr(ca(12'h555, b), 16'h90);
    if (exp_mode == RD || exp_mode == AS) begin
      exp_mode = AS;
      chk("R5 auto-select bank", asel_bank_o, b);
    end else exp_mode = fail_to(exp_mode);
    chk("R5 auto-select mode", mode_o, exp_mode);
  endtask

  task automatic op_qry();
    wr(ca(12'h055, 0), 16'h98);
    if (exp_mode == RD || exp_mode == AS) begin exp_qret = exp_mode; exp_mode = QY; end
    else exp_mode = fail_to(exp_mode);
    chk("R6 query entry", mode_o, exp_mode);
  endtask

  task automatic op_garb();
    wr(ca(12'h555, 0), 16'hAA); wr(ca(12'h2AB, 0), 16'h55);
    exp_mode = fail_to(exp_mode);
    chk("R2 broken unlock", mode_o, exp_mode);
  endtask

  task automatic op_prog(input bit fail);
    logic [AW-1:0] a; logic [DW-1:0] d;
    a = AW'($urandom); d = DW'($urandom_range(63)) | 16'h1200;
    wr(ca(12'h555, 0), 16'hAA); wr(ca(12'h2AA, 0), 16'h55); wr(ca(12'h555, 0), 16'hA0);
    wr(a, d);
    if (exp_mode == RD) begin
      chk("R3 len", prog_len_o, 1);
      chk("R3 slot0 addr", prog_addr_o[AW-1:0], a);
      chk("R3 slot0 data", prog_data_o[DW-1:0], d);
      engine("R3 program", fail, RD);
    end else begin
      exp_mode = fail_to(exp_mode);
      chk("R2 program refused", mode_o, exp_mode);
      chk("R2 no start", prog_start_o, 0);
    end
  endtask

  task automatic op_fast(input int n, input bit ok, input bit fail);
    logic [AW-1:0] base, a; logic [DW-1:0] d; bit was_rd;
    was_rd = (exp_mode == RD);
    base = AW'($urandom) & ~AW'(3);
    wr(ca(12'h555, 0), (n == 4) ? 16'h56 : 16'h50);
    for (int i = 0; i < n; i++) begin
      a = base + AW'(i);
      if (!ok && i == n - 1) a = a ^ AW'(32);
      d = DW'($urandom_range(63));
      wr(a, d);
      if (was_rd && ok) begin
        chk("R7/R8 slot addr", prog_addr_o[i*AW +: AW], a);
        chk("R7/R8 slot data", prog_data_o[i*DW +: DW], d);
      end
    end
    if (was_rd && ok) begin
      chk("R7/R8 len", prog_len_o, n);
      engine("R7/R8 fast", fail, RD);
    end else begin
      exp_mode = was_rd ? RD : fail_to(exp_mode);
      chk("R9 no start", prog_start_o, 0);
      chk("R9 mode", mode_o, exp_mode);
    end
  endtask

  task automatic op_bypon();
    wr(ca(12'h555, 0), 16'hAA); wr(ca(12'h2AA, 0), 16'h55); wr(ca(12'h555, 0), 16'h20);
    exp_mode = (exp_mode == RD) ? BP : fail_to(exp_mode);
    chk("R10 bypass entry", mode_o, exp_mode);
  endtask

  task automatic op_bpg(input bit fail);
    logic [AW-1:0] a; logic [DW-1:0] d;
    a = AW'($urandom); d = DW'($urandom);
    wr(AW'($urandom), 16'hA0); wr(a, d);
    chk("R10 bypass len", prog_len_o, 1);
    chk("R10 bypass addr", prog_addr_o[AW-1:0], a);
    chk("R10 bypass data", prog_data_o[DW-1:0], d);
    engine("R10 bypass program", fail, BP);
  endtask

  task automatic op_bypoff();
    wr(AW'($urandom), 16'h90); wr(AW'($urandom), 16'h00);
    exp_mode = RD;
    chk("R10 bypass exit", mode_o, exp_mode);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 reset mode", mode_o, RD);
    chk("R1 reset start", prog_start_o, 0);
    rst_ni = 1;
    @(negedge clk);
    // directed corner cases
    op_garb();
    op_asel(1); op_qry(); op_rst1();
    chk("R6 first reset back to auto-select", mode_o, AS);
    op_rst1();
    chk("R6 second reset to read", mode_o, RD);
    op_prog(1);
    chk("R11 fail gives error", mode_o, ER);
    op_garb(); op_rst3();
    chk("R4 error cleared", mode_o, RD);
    op_fast(4, 1, 0); op_fast(2, 1, 0); op_fast(4, 0, 0); op_fast(2, 0, 0);
    byte_mode = 1; op_prog(0); op_asel(0); op_rst1(); byte_mode = 0;  // R12
    op_bypon(); op_rst1();
    chk("R10 F0 keeps bypass", mode_o, BP);
    op_bpg(0); op_bpg(1); op_rst1(); op_bypon(); op_bypoff();
    // random command mix
    for (int it = 0; it < 400; it++) begin
      int k;
      byte_mode = 1'($urandom);
      k = $urandom_range(10);
      if (exp_mode == BP) begin
        if (k < 3) op_rst1(); else if (k < 8) op_bpg(($urandom_range(7)) == 0); else op_bypoff();
      end else begin
        case (k)
          0: op_rst1();
          1: op_rst3();
          2: op_asel(1'($urandom));
          3: op_qry();
          4: op_prog(($urandom_range(7)) == 0);
          5: op_fast(4, ($urandom_range(3)) != 0, 0);
          6: op_fast(2, ($urandom_range(3)) != 0, ($urandom_range(7)) == 0);
          7: op_bypon();
          8: op_garb();
          default: op_asel(0);
        endcase
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule